// File: doc/BRIEF.md
# Serial Receive Queue with Overrun and Timeout Guard

This block is the receive-side word queue of a serial port. It stores up to eight completed words from the receiver's shift stage and hands them to the CPU in arrival order. The oldest stored word is always visible on the read data port. A read strobe removes that word.

When a word completes and the queue is full, the block raises an overrun interrupt in the next cycle. From then on, every completed word is thrown away until software writes a 1 to the overrun clear input. A read in the same cycle as a completion frees a slot, so that word is kept. The overrun check is made only at the moment a word completes. A read made while the ninth word is still being received therefore prevents the overrun.

Clearing the overrun arms a receive timeout. If the queue still holds data and no read happens within 32 bit-period ticks, the timeout interrupt is raised. Any read, or the queue running empty, restarts the count and withdraws the timeout.

Top module: `rx_fifo_guard`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to empty=1, full=0, ovr_irq=0 and tmo_irq=0.
- R2: Words leave in the order they completed, and rd_data shows the oldest stored word whenever empty is 0.
- R3: full is 1 exactly when 8 words are stored and empty is 1 exactly when none are. A read and an accepted word in the same cycle leave the occupancy unchanged.
- R4: If word_done is 1 while the queue is full, ovr_irq is 0 and rd_en is 0, then ovr_irq is 1 from the next cycle and that word is discarded.
- R5: While ovr_irq is 1, every completed word is discarded and the stored contents do not change except through reads.
- R6: If rd_en is 1 on a non-empty queue in the same cycle that a word completes on a full queue, the word is stored and no overrun is raised.
- R7: ovr_clr=1 drops ovr_irq in the next cycle. After that, completed words are accepted whenever a slot is free, even if the queue was never drained.
- R8: After ovr_clr, if the queue stays non-empty and unread, tmo_irq rises in the cycle after the 32nd counted bit_tick. The count restarts on each ovr_clr.
- R9: A read of a non-empty queue, or the queue being empty, clears tmo_irq in the next cycle and restarts the count. An empty queue also disarms the timeout until the next ovr_clr.
- R10: A bit_tick arriving while rx_busy is 1 is not counted toward the timeout.
- R11: rd_en while the queue is empty is ignored: occupancy, order and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_done | input | 1 | One-cycle strobe: a received word is complete |
| word_data | input | 16 | The completed word |
| rx_busy | input | 1 | A word is currently being shifted in |
| rd_en | input | 1 | CPU read strobe: removes the oldest word |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun interrupt |
| bit_tick | input | 1 | One pulse per bit period |
| rd_data | output | 16 | Oldest stored word |
| empty | output | 1 | No word stored |
| full | output | 1 | Eight words stored |
| ovr_irq | output | 1 | Overrun interrupt |
| tmo_irq | output | 1 | Receive timeout interrupt |

## Verification
A wrong occupancy count shows up at once. full or empty flips in the wrong cycle, and rd_data shows a word out of order on the next read. A read-pointer slip is seen as a wrong rd_data value within one cycle of the read. An overrun flag that sets late, or clears and sets in the wrong cycle, lets a discarded word into the queue. That word surfaces at rd_data once the words ahead of it are read out. A timer off by one tick moves the tmo_irq edge by one tick. The bench catches this because it samples the edge exactly.

// File: rtl/rxf_pkg.sv
// Package: shared defaults for the receive queue guard.
// Assumes: consumers derive their own widths from these values.
package rxf_pkg;
    parameter int unsigned RXF_DATA_W   = 16;
    parameter int unsigned RXF_DEPTH    = 8;
    parameter int unsigned RXF_TMO_BITS = 32;
endpackage

// File: rtl/rxf_store.sv
// Module: rxf_store
// Circular word store with an occupancy count and show-ahead read data.
// Assumes: push is only requested when a slot is free or pop frees one in
// the same cycle; pop is only requested when the store is not empty.
module rxf_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;

    // Write the incoming word into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers with wrap and track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    // Present the oldest word and the occupancy flags.
    always_comb begin
        rdata = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_balanced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count));
endmodule

// File: rtl/rxf_ovr.sv
// Module: rxf_ovr
// Overrun flag: set when a word completes on a full store that no read
// relieves in that cycle; cleared by a write-one-to-clear strobe.
// Assumes: the clear strobe takes priority over a new overrun in the same cycle.
module rxf_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic word_done,
    input  logic full,
    input  logic pop,
    input  logic ovr_clr,
    output logic ovr_irq
);
    // Hold, set or clear the overrun interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_irq <= 1'b0;
        end else if (ovr_clr) begin
            ovr_irq <= 1'b0;
        end else if (word_done && full && !pop) begin
            ovr_irq <= 1'b1;
        end
    end

    assert_ovr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_irq) |-> $past(word_done && full && !pop));
    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_irq && !ovr_clr) |=> ovr_irq);
    assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> !ovr_irq);
endmodule

// File: rtl/rxf_tmo.sv
// Module: rxf_tmo
// Receive timeout: armed by an overrun clear, counts bit ticks while the
// store is non-empty, unread and no word is in reception; raises the
// interrupt after TMO_BITS counted ticks.
// Assumes: pop is a read of a non-empty store; empty disarms the timer.
module rxf_tmo #(
    parameter int unsigned TMO_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_clr,
    input  logic pop,
    input  logic empty,
    input  logic bit_tick,
    input  logic rx_busy,
    output logic tmo_irq
);
    localparam int unsigned TW = (TMO_BITS > 1) ? $clog2(TMO_BITS) : 1;

    logic          armed;
    logic [TW-1:0] cnt;

    // Arm on clear, restart on read or empty, count eligible ticks otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            cnt     <= '0;
            tmo_irq <= 1'b0;
        end else if (ovr_clr) begin
            armed   <= 1'b1;
            cnt     <= '0;
            tmo_irq <= 1'b0;
        end else if (!armed || pop || empty) begin
            cnt     <= '0;
            tmo_irq <= 1'b0;
            if (empty) begin
                armed <= 1'b0;
            end
        end else if (bit_tick && !rx_busy && !tmo_irq) begin
            if (cnt == TW'(TMO_BITS - 1)) begin
                tmo_irq <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_tmo_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || empty) |=> !tmo_irq);
    assert_tmo_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && !ovr_clr && !pop && !empty) |=> ($stable(cnt) && !$rose(tmo_irq)));
    assert_tmo_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> $past(armed && bit_tick && !rx_busy));
endmodule

// File: rtl/rx_fifo_guard.sv
// Module: rx_fifo_guard (top)
// Receive word queue with overrun detection at word completion and a
// receive timeout armed by the overrun clear.
// Assumes: word_done is a single-cycle strobe with word_data valid alongside.
module rx_fifo_guard #(
    parameter int unsigned DATA_W   = rxf_pkg::RXF_DATA_W,
    parameter int unsigned DEPTH    = rxf_pkg::RXF_DEPTH,
    parameter int unsigned TMO_BITS = rxf_pkg::RXF_TMO_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              rx_busy,
    input  logic              rd_en,
    input  logic              ovr_clr,
    input  logic              bit_tick,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              ovr_irq,
    output logic              tmo_irq
);
    logic push;
    logic pop;

    // Accept a read only when data exists; accept a word only when no overrun
    // is pending and a slot is free now or freed by this cycle's read.
    always_comb begin
        pop  = rd_en && !empty;
        push = word_done && !ovr_irq && (!full || pop);
    end

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (word_data),
        .rdata (rd_data),
        .empty (empty),
        .full  (full)
    );

    rxf_ovr u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .full      (full),
        .pop       (pop),
        .ovr_clr   (ovr_clr),
        .ovr_irq   (ovr_irq)
    );

    rxf_tmo #(.TMO_BITS(TMO_BITS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_clr  (ovr_clr),
        .pop      (pop),
        .empty    (empty),
        .bit_tick (bit_tick),
        .rx_busy  (rx_busy),
        .tmo_irq  (tmo_irq)
    );

    assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_irq && !ovr_clr && !rd_en) |=> ($stable(empty) && $stable(full)));
    assert_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    assert_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && full && !ovr_irq && rd_en) |=> (full && !ovr_irq));
endmodule

// File: tb/rx_fifo_guard_tb.sv
`timescale 1ns/1ps
module rx_fifo_guard_tb;
    localparam int TB_DEPTH = 8;
    localparam int TB_TMO   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_done = 1'b0;
    logic [15:0] word_data = '0;
    logic        rx_busy = 1'b0;
    logic        rd_en = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        bit_tick = 1'b0;
    logic [15:0] rd_data;
    logic        empty, full, ovr_irq, tmo_irq;

    int checks = 0;
    int fails  = 0;

    // bench-side reference state
    int m_q[$];
    bit m_ovr, m_armed, m_tmo;
    int m_cnt;

    always #2 clk = ~clk;

    rx_fifo_guard u_dut (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
        .rx_busy(rx_busy), .rd_en(rd_en), .ovr_clr(ovr_clr), .bit_tick(bit_tick),
        .rd_data(rd_data), .empty(empty), .full(full), .ovr_irq(ovr_irq),
        .tmo_irq(tmo_irq)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all ports against the reference state
    task automatic check_all();
        check("R3 empty", empty, m_q.size() == 0);
        check("R3 full", full, m_q.size() == TB_DEPTH);
        check("R4 ovr_irq", ovr_irq, m_ovr);
        check("R8 tmo_irq", tmo_irq, m_tmo);
        if (m_q.size() > 0) check("R2 rd_data", rd_data, m_q[0]);
    endtask

    // one clock: drive at the falling edge, update the reference, check after
    task automatic cyc(input bit wd, input int d, input bit busy, input bit rd,
                       input bit clr, input bit tk);
        bit was_empty, pop, push, n_ovr, n_armed, n_tmo;
        int n_cnt;
        word_done = wd; word_data = d[15:0]; rx_busy = busy;
        rd_en = rd; ovr_clr = clr; bit_tick = tk;
        was_empty = (m_q.size() == 0);
        pop  = rd && !was_empty;
        push = wd && !m_ovr && ((m_q.size() < TB_DEPTH) || pop);
        n_ovr = clr ? 1'b0 : ((wd && !m_ovr && m_q.size() == TB_DEPTH && !rd) ? 1'b1 : m_ovr);
        n_armed = m_armed; n_cnt = m_cnt; n_tmo = m_tmo;
        if (clr) begin
            n_armed = 1; n_cnt = 0; n_tmo = 0;
        end else if (!m_armed || pop || was_empty) begin
            n_cnt = 0; n_tmo = 0;
            if (was_empty) n_armed = 0;
        end else if (tk && !busy && !m_tmo) begin
            if (m_cnt == TB_TMO - 1) n_tmo = 1; else n_cnt = m_cnt + 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (pop) void'(m_q.pop_front());
        if (push) m_q.push_back(d & 16'hffff);
        m_ovr = n_ovr; m_armed = n_armed; m_cnt = n_cnt; m_tmo = n_tmo;
        word_done = 0; rd_en = 0; ovr_clr = 0; bit_tick = 0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_q.delete(); m_ovr = 0; m_armed = 0; m_tmo = 0; m_cnt = 0;
        @(negedge clk);
        // R1: state after reset
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 ovr", ovr_irq, 0);
        check("R1 tmo", tmo_irq, 0);

        // R3: fill eight words
        for (int i = 0; i < TB_DEPTH; i++) cyc(1, 16'h100 + i, 0, 0, 0, 0);
        check("R3 full after 8", full, 1);
        // R6: ninth completes together with a read
        cyc(1, 16'h200, 1, 1, 0, 0);
        check("R6 no overrun", ovr_irq, 0);
        check("R6 still full", full, 1);
        // R4: ninth completes with no read
        cyc(1, 16'h300, 0, 0, 0, 0);
        check("R4 overrun raised", ovr_irq, 1);
        // R5: further words discarded
        cyc(1, 16'h301, 0, 0, 0, 0);
        check("R5 head unchanged", rd_data, 16'h101);
        check("R5 still full", full, 1);
        // R7: clear and accept into freed slot
        cyc(0, 0, 0, 0, 1, 0);
        check("R7 ovr cleared", ovr_irq, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(1, 16'h400, 0, 0, 0, 0);
        check("R7 accepted", full, 1);
        check("R7 no overrun", ovr_irq, 0);
        // R10: ticks during reception not counted
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 0, 1);
        check("R10 no timeout", tmo_irq, 0);
        // R8: 32 counted ticks raise timeout
        for (int i = 0; i < TB_TMO - 1; i++) cyc(0, 0, 0, 0, 0, 1);
        check("R8 not yet", tmo_irq, 0);
        cyc(0, 0, 0, 0, 0, 1);
        check("R8 timeout", tmo_irq, 1);
        // R9: read clears timeout
        cyc(0, 0, 0, 1, 0, 0);
        check("R9 cleared", tmo_irq, 0);
        // R11: drain, then read on empty
        while (m_q.size() > 0) cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check("R11 empty kept", empty, 1);
        check("R11 full kept", full, 0);
        cyc(1, 16'h555, 0, 0, 0, 0);
        check("R11 order intact", rd_data, 16'h555);

        // random phases with varying read pressure
        void'($urandom(32'h5eed));
        for (int ph = 0; ph < 6; ph++) begin
            int rd_pct;
            rd_pct = (ph % 2 == 0) ? 5 : 35;
            for (int i = 0; i < 700; i++) begin
                cyc(($urandom % 100) < 30, $urandom & 16'hffff, ($urandom % 100) < 20,
                    ($urandom % 100) < rd_pct, ($urandom % 100) < 2, ($urandom % 100) < 60);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule